// File: doc/BRIEF.md
# SPI GPIO Expander Register Target

This block is the serial-side core of an eight-pin general-purpose I/O expander. A host reaches it over an SPI bus in mode 0, most significant bit first. Each transaction opens with a control byte. The control byte carries a fixed device code, a three-bit sub-address and a direction bit. A register address byte follows. After that come data bytes, either shifted in by the host or shifted out by the block. The block holds the configuration registers. It drives pad output enables and output levels from them, and it returns the sampled pad levels on request.

Several expanders can share one chip select. When address matching is switched on, a device takes part only in transactions whose sub-address equals its strap pins. The block also passes its interrupt configuration registers to a separate interrupt unit. It takes back that unit's flag and capture bytes, which the host can read.

All serial inputs are brought into the system clock domain through two-stage synchronizers. SCK edges are detected there. The system clock must therefore run several times faster than SCK.

Top module: `spi_gpio_expander`

## Requirements
- R1: After reset all pads are inputs (pad_oe = 0x00), pad_out = 0x00, every configuration output is 0x00 and spi_miso_oe is low.
- R2: A control byte takes part only if bits 7:4 equal 4'b0100. Bits 3:1 carry the sub-address and bit 0 is 1 for a read and 0 for a write. A control byte with any other code leaves every register unchanged.
- R3: When control bit 3 (address match enable, register 0x05) is 1, a transaction is accepted only if its sub-address equals hw_addr. A rejected device neither writes nor drives spi_miso_oe. When that bit is 0, any sub-address is accepted.
- R4: A write is control byte, then register address, then data. Register 0x00 holds the direction, where 1 means input, and pad_oe is its bitwise inverse. Register 0x01 is input polarity, 0x02 interrupt enable, 0x03 compare value, 0x04 interrupt mode, 0x05 control and 0x06 pull-up enable.
- R5: pad_out always equals the output latch (0x0A). A write to the port register (0x09) also loads the output latch.
- R6: A read of 0x09 returns pad_in XOR the polarity register. Reads of 0x07 and 0x08 return irq_flag and irq_capture. Writes to 0x07 and 0x08 are ignored.
- R7: When control bit 5 (register 0x05) is 0, each data byte advances the register pointer by one, and the pointer wraps from 0x0A to 0x00. When it is 1, the pointer stays on the addressed register for the whole burst.
- R8: Addresses above 0x0A read as 0x00, and writes to them change nothing.
- R9: Data is sampled on rising SCK and shifted out on falling SCK, most significant bit first. spi_miso_oe is high only during the data phase of an accepted read and is low whenever chip select is high.
- R10: Raising chip select in the middle of a byte discards that byte without any register update. Registers change only on a completed data byte inside a frame.
- R11: cfg_inten, cfg_defval, cfg_intcon, cfg_ctrl and pull_en present registers 0x02, 0x03, 0x04, 0x05 and 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_addr | input | 3 | Strap pins compared against the sub-address |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| pad_in | input | 8 | Sampled pad levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output levels |
| irq_flag | input | 8 | Flag byte from interrupt unit |
| irq_capture | input | 8 | Capture byte from interrupt unit |
| cfg_inten | output | 8 | Interrupt enable register |
| cfg_defval | output | 8 | Compare value register |
| cfg_intcon | output | 8 | Interrupt mode register |
| cfg_ctrl | output | 8 | Control register |
| pull_en | output | 8 | Pull-up enable register |

## Verification
The assertions rely on a few conditions on the inputs. SCK must be low whenever chip select falls or rises. Each SCK level must last at least four system clocks, so every edge is seen after synchronization before the next one arrives. spi_cs_n must hold its value from time zero until reset ends. The stimulus uses eight clocks per SCK level. It leaves guard intervals of several clocks around every chip-select change. Chip select is only released while SCK is low, even in the aborted-byte case.

// File: rtl/spi_gpio_expander.sv
module spi_gpio_expander #(
  parameter logic [3:0] DEV_CODE = 4'b0100
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hw_addr,
  input  logic       spi_cs_n,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  input  logic [7:0] pad_in,
  output logic [7:0] pad_oe,
  output logic [7:0] pad_out,
  input  logic [7:0] irq_flag,
  input  logic [7:0] irq_capture,
  output logic [7:0] cfg_inten,
  output logic [7:0] cfg_defval,
  output logic [7:0] cfg_intcon,
  output logic [7:0] cfg_ctrl,
  output logic [7:0] pull_en
);
  localparam logic [7:0] A_DIR  = 8'h00, A_POL = 8'h01, A_IEN = 8'h02, A_CMP  = 8'h03,
                         A_IMOD = 8'h04, A_CTL = 8'h05, A_PUL = 8'h06, A_FLAG = 8'h07,
                         A_CAP  = 8'h08, A_PRT = 8'h09, A_LAT = 8'h0A;
  localparam int B_HOLD  = 5;
  localparam int B_MATCH = 3;
  localparam logic [1:0] PH_CTRL = 2'd0, PH_ADDR = 2'd1, PH_DATA = 2'd2;

  logic [1:0] sck_q, cs_q, mosi_q;
  logic       sck_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0; cs_q <= '1; mosi_q <= '0; sck_d <= 1'b0;
    end else begin
      sck_q  <= {sck_q[0], spi_sck};
      cs_q   <= {cs_q[0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
      sck_d  <= sck_q[1];
    end

  wire active = ~cs_q[1];
  wire rise   = sck_q[1] & ~sck_d;
  wire fall   = ~sck_q[1] & sck_d;

  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [1:0] phase;
  logic       sel, rd;
  logic [7:0] ptr, tx_sh;
  logic [7:0] dir, pol, ien, cmp, imod, ctl, pul, lat;
  logic [7:0] rdata;

  wire [7:0] rx_byte   = {rx_sh, mosi_q[1]};
  wire       byte_done = active & rise & (bit_cnt == 3'd7);
  wire       ctrl_ok   = (rx_byte[7:4] == DEV_CODE) & (~ctl[B_MATCH] | (rx_byte[3:1] == hw_addr));
  wire [7:0] ptr_nx    = ctl[B_HOLD] ? ptr : ((ptr == A_LAT) ? 8'h00 : ptr + 8'd1);
  wire       wr_en     = byte_done & (phase == PH_DATA) & sel & ~rd;
  wire       load      = active & fall & (bit_cnt == 3'd0) & (phase == PH_DATA) & sel & rd;

  always_comb
    case (ptr)
      A_DIR:   rdata = dir;
      A_POL:   rdata = pol;
      A_IEN:   rdata = ien;
      A_CMP:   rdata = cmp;
      A_IMOD:  rdata = imod;
      A_CTL:   rdata = ctl;
      A_PUL:   rdata = pul;
      A_FLAG:  rdata = irq_flag;
      A_CAP:   rdata = irq_capture;
      A_PRT:   rdata = pad_in ^ pol;
      A_LAT:   rdata = lat;
      default: rdata = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0; rx_sh <= '0; phase <= PH_CTRL; sel <= 1'b0; rd <= 1'b0;
      ptr <= '0; tx_sh <= '0;
    end else if (!active) begin
      bit_cnt <= '0; phase <= PH_CTRL; sel <= 1'b0; rd <= 1'b0; tx_sh <= '0;
    end else begin
      if (rise) begin
        rx_sh   <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_done)
        case (phase)
          PH_CTRL: begin sel <= ctrl_ok; rd <= rx_byte[0]; phase <= PH_ADDR; end
          PH_ADDR: begin ptr <= rx_byte; phase <= PH_DATA; end
          default: if (wr_en) ptr <= ptr_nx;
        endcase
      if (load) begin
        tx_sh <= rdata;
        ptr   <= ptr_nx;
      end else if (fall)
        tx_sh <= {tx_sh[6:0], 1'b0};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir <= 8'hFF; pol <= '0; ien <= '0; cmp <= '0; imod <= '0; ctl <= '0; pul <= '0; lat <= '0;
    end else if (wr_en)
      case (ptr)
        A_DIR:          dir  <= rx_byte;
        A_POL:          pol  <= rx_byte;
        A_IEN:          ien  <= rx_byte;
        A_CMP:          cmp  <= rx_byte;
        A_IMOD:         imod <= rx_byte;
        A_CTL:          ctl  <= rx_byte;
        A_PUL:          pul  <= rx_byte;
        A_PRT, A_LAT:   lat  <= rx_byte;
        default: ;
      endcase

  assign pad_oe      = ~dir;
  assign pad_out     = lat;
  assign cfg_inten   = ien;
  assign cfg_defval  = cmp;
  assign cfg_intcon  = imod;
  assign cfg_ctrl    = ctl;
  assign pull_en     = pul;
  assign spi_miso_oe = active & sel & rd & (phase == PH_DATA);
  assign spi_miso    = spi_miso_oe & tx_sh[7];

  AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) |-> !spi_miso_oe);  // R9
  AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !spi_miso_oe);  // R3
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(pad_oe) && $stable(pad_out) && $stable(cfg_ctrl));  // R10
  AST_WRITE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out != $past(pad_out)) |-> $past(byte_done));  // R10
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && phase == PH_DATA) |=> $stable(pad_out) && $stable(pad_oe));  // R6
endmodule

// File: tb/test_spi_gpio_expander.sv
module test_spi_gpio_expander;
  localparam int HALF = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] hw_addr = 3'd5;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic [7:0] pad_in = 8'h3C, irq_flag = 8'h81, irq_capture = 8'h42;
  logic [7:0] pad_oe, pad_out, cfg_inten, cfg_defval, cfg_intcon, cfg_ctrl, pull_en;

  always #4 clk = ~clk;

  spi_gpio_expander i_spi_gpio_expander (
    .clk(clk), .rst_n(rst_n), .hw_addr(hw_addr),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .irq_flag(irq_flag), .irq_capture(irq_capture),
    .cfg_inten(cfg_inten), .cfg_defval(cfg_defval), .cfg_intcon(cfg_intcon),
    .cfg_ctrl(cfg_ctrl), .pull_en(pull_en));

  int vectors = 0, miscompares = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rx_data;
  event       rx_ev;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_rd(logic [7:0] v, string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  initial forever begin
    @(rx_ev);
    vectors++;
    if (exp_q.size() == 0) begin
      miscompares++;
      $display("FAIL read-data unexpected actual=%h expected=none", rx_data);
    end else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      if (rx_data !== e) begin
        miscompares++;
        $display("FAIL %s read actual=%h expected=%h", t, rx_data, e);
      end
    end
  end

  task automatic spi_bits(logic [7:0] tx, int n, bit cap);
    logic [7:0] rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk) spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
    if (cap) begin
      rx_data = rx;
      ->rx_ev;
    end
  endtask

  task automatic cs_begin();
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] sub, logic [7:0] a, logic [7:0] d);
    cs_begin();
    spi_bits({4'h4, sub, 1'b0}, 8, 0);
    spi_bits(a, 8, 0);
    spi_bits(d, 8, 0);
    cs_end();
  endtask

  task automatic rd_burst(logic [2:0] sub, logic [7:0] a, int n);
    cs_begin();
    spi_bits({4'h4, sub, 1'b1}, 8, 0);
    spi_bits(a, 8, 0);
    for (int k = 0; k < n; k++) spi_bits(8'h00, 8, 1);
    cs_end();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 cfg_ctrl", cfg_ctrl, 8'h00);
    chk("R1 cfg_inten", cfg_inten, 8'h00);
    chk("R1 miso_oe", {7'd0, spi_miso_oe}, 8'h00);

    // R3: match disabled, sub-address 3 accepted although hw_addr is 5
    wr(3'd3, 8'h0A, 8'hA5);
    wr(3'd3, 8'h00, 8'h0F);
    chk("R5 pad_out latch", pad_out, 8'hA5);
    chk("R4 pad_oe inverse of direction", pad_oe, 8'hF0);

    // R2: wrong device code
    cs_begin();
    spi_bits(8'h26, 8, 0);
    spi_bits(8'h0A, 8, 0);
    spi_bits(8'h00, 8, 0);
    cs_end();
    chk("R2 bad code ignored", pad_out, 8'hA5);

    wr(3'd3, 8'h01, 8'hFF);
    expect_rd(8'hC3, "R6 port xor polarity");
    rd_burst(3'd3, 8'h09, 1);
    expect_rd(8'h81, "R6 flag");
    rd_burst(3'd3, 8'h07, 1);
    expect_rd(8'h42, "R6 capture");
    rd_burst(3'd3, 8'h08, 1);

    // R7: sequential write burst
    cs_begin();
    spi_bits(8'h46, 8, 0);
    spi_bits(8'h02, 8, 0);
    spi_bits(8'h11, 8, 0);
    spi_bits(8'h22, 8, 0);
    spi_bits(8'h33, 8, 0);
    cs_end();
    chk("R7 R11 cfg_inten", cfg_inten, 8'h11);
    chk("R7 R11 cfg_defval", cfg_defval, 8'h22);
    chk("R7 R11 cfg_intcon", cfg_intcon, 8'h33);
    wr(3'd3, 8'h06, 8'h44);
    chk("R11 pull_en", pull_en, 8'h44);

    wr(3'd3, 8'h07, 8'h00);
    expect_rd(8'h81, "R6 flag write ignored");
    rd_burst(3'd3, 8'h07, 1);

    // R7: full burst with wrap back to 0x00
    expect_rd(8'h0F, "R7 burst dir");
    expect_rd(8'hFF, "R7 burst pol");
    expect_rd(8'h11, "R7 burst ien");
    expect_rd(8'h22, "R7 burst cmp");
    expect_rd(8'h33, "R7 burst imod");
    expect_rd(8'h00, "R7 burst ctl");
    expect_rd(8'h44, "R7 burst pull");
    expect_rd(8'h81, "R7 burst flag");
    expect_rd(8'h42, "R7 burst cap");
    expect_rd(8'hC3, "R7 burst port");
    expect_rd(8'hA5, "R7 burst latch");
    expect_rd(8'h0F, "R7 burst wrap");
    rd_burst(3'd3, 8'h00, 12);

    // R9: output enable only in data phase
    cs_begin();
    spi_bits(8'h47, 8, 0);
    spi_bits(8'h0A, 8, 0);
    repeat (2) @(negedge clk);
    chk("R9 oe in data phase", {7'd0, spi_miso_oe}, 8'h01);
    expect_rd(8'hA5, "R9 msb-first latch read");
    spi_bits(8'h00, 8, 1);
    cs_end();
    chk("R9 oe idle", {7'd0, spi_miso_oe}, 8'h00);

    // R8: out-of-range address
    wr(3'd3, 8'h0B, 8'hFF);
    chk("R8 write ignored latch", pad_out, 8'hA5);
    chk("R8 write ignored dir", pad_oe, 8'hF0);
    expect_rd(8'h00, "R8 read 0x0B");
    expect_rd(8'h00, "R8 read 0x0C");
    rd_burst(3'd3, 8'h0B, 2);

    // R10: abort mid-byte
    cs_begin();
    spi_bits(8'h46, 8, 0);
    spi_bits(8'h0A, 8, 0);
    spi_bits(8'h00, 4, 0);
    cs_end();
    chk("R10 aborted byte", pad_out, 8'hA5);

    // R3: address match enabled
    wr(3'd3, 8'h05, 8'h08);
    chk("R11 cfg_ctrl", cfg_ctrl, 8'h08);
    wr(3'd3, 8'h0A, 8'h00);
    chk("R3 mismatched write ignored", pad_out, 8'hA5);
    cs_begin();
    spi_bits(8'h47, 8, 0);
    spi_bits(8'h0A, 8, 0);
    repeat (2) @(negedge clk);
    chk("R3 mismatched read no drive", {7'd0, spi_miso_oe}, 8'h00);
    spi_bits(8'h00, 8, 0);
    cs_end();
    wr(3'd5, 8'h0A, 8'h5A);
    chk("R3 matched write", pad_out, 8'h5A);

    // R7: hold pointer
    wr(3'd5, 8'h05, 8'h28);
    chk("R11 cfg_ctrl hold", cfg_ctrl, 8'h28);
    expect_rd(8'h5A, "R7 hold read 1");
    expect_rd(8'h5A, "R7 hold read 2");
    expect_rd(8'h5A, "R7 hold read 3");
    rd_burst(3'd5, 8'h0A, 3);
    cs_begin();
    spi_bits(8'h4A, 8, 0);
    spi_bits(8'h0A, 8, 0);
    spi_bits(8'h11, 8, 0);
    spi_bits(8'h22, 8, 0);
    cs_end();
    chk("R7 hold write last", pad_out, 8'h22);
    chk("R7 hold no wrap to dir", pad_oe, 8'hF0);

    wr(3'd5, 8'h09, 8'h77);
    chk("R5 port write loads latch", pad_out, 8'h77);

    repeat (10) @(negedge clk);
    chk("R9 pending reads consumed", 8'(exp_q.size()), 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule